// File: doc/BRIEF.md
# Programmable PCM Frame Timing Generator

This block produces the bit-level timing of a two-wire serial audio link: the bit clock, the frame sync, and a bit-position count. A serializer uses these to place channel data. The whole block runs on one system clock. Acting as provider, it divides that clock to make the bit clock and drives the frame sync from its own position counter. Acting as consumer, it oversamples an external bit clock and/or frame sync through synchronizers and follows them. The bit-clock role and the frame-sync role are chosen separately.

A single configuration word sets the frame length, the sync pulse length and both roles. It also picks which bit-clock edge is the sampling edge, and whether a frame begins on a rising or a falling sync transition. Because all of these are set at run time, one engine covers the standard stereo format, the left-justified and right-justified formats, and single-pulse DSP-style framing. The configuration is taken only while the transmit and receive paths are both off. After enable, the block lets a few bit clocks go by before it starts counting.

Top module: `pcm_frame_timer`

## Requirements
- R1: With frame field L (cfg_word[9:0], bit clocks per frame minus one), bit_pos takes the values 0,1,…,L,0,… on successive bit_step pulses. frame_start is a one-cycle strobe that is high exactly when bit_pos has just become 0. The first counted step of a run lands on 0.
- R2: As sync provider (cfg_word[21]=0), fs_out is active while bit_pos < S, where S is cfg_word[19:10], and inactive otherwise. The active level is high when cfg_word[23]=0 and low when cfg_word[23]=1.
- R3: As bit-clock provider (cfg_word[20]=0), bclk_out toggles every HALF_DIV system clocks while en is high. bclk_out is 0 while en is low.
- R4: cfg_word[22]=1 means data is sampled on the rising bit-clock edge, so bit_step pulses on the falling edge. cfg_word[22]=0 swaps the edges. No bit_step occurs on the other edge.
- R5: As bit-clock consumer (cfg_word[20]=1), there is one bit_step for each launch edge of bclk_in beyond the warm-up, and bclk_out stays 0.
- R6: As sync consumer (cfg_word[21]=1), a frame-start transition of fs_in sets bit_pos to 0 and raises frame_start on that bit_step. The transition is rising when cfg_word[23]=0 and falling when cfg_word[23]=1. Without such a transition the counter wraps as in R1. fs_out stays 0.
- R7: After en rises, the first WARM_BITS launch edges produce no bit_step. Counting starts on the next launch edge.
- R8: While en is low: no bit_step, no frame_start, bit_pos is 0, and a sync provider holds fs_out at its inactive level.
- R9: cfg_word is taken only in cycles where tx_on and rx_on are both 0. A word presented while either is 1 has no effect on framing.
- R10: While rst is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the block idle |
| tx_on | input | 1 | Transmit path active; blocks configuration update |
| rx_on | input | 1 | Receive path active; blocks configuration update |
| cfg_word | input | 24 | Frame length-1, sync length, roles, edge and polarity controls |
| bclk_in | input | 1 | External bit clock for consumer role |
| fs_in | input | 1 | External frame sync for consumer role |
| bclk_out | output | 1 | Generated bit clock (0 when consumer) |
| fs_out | output | 1 | Generated frame sync (0 when consumer) |
| bit_step | output | 1 | One-cycle strobe on each counted launch edge |
| bit_pos | output | 10 | Current bit position within the frame |
| frame_start | output | 1 | One-cycle strobe when bit_pos returns to 0 |

## Verification
In provider clocking, bclk_out toggles and bit_step pulses in the same system cycle. bit_pos, frame_start and fs_out take their new values one cycle later. In consumer clocking, bit_step follows an edge of bclk_in by three system cycles. The sync sample used for that step is the fs_in value driven together with that edge. A new configuration word takes effect one cycle after it is presented. The bench samples every output at the falling system-clock edge and finds launch edges from the sampled bclk_out (or from its own bclk_in drive). It checks bit_step in the cycle of the edge and checks position, strobe and sync level in the following cycle, against a counter model kept in the bench.

// File: rtl/pcm_tgen_pkg.sv
package pcm_tgen_pkg;

    parameter int FL_W = 10;
    localparam int CFG_W = 2 * FL_W + 4;

    // Field order fixes the configuration word layout (MSB first).
    typedef struct packed {
        logic            fs_fall;    // frame begins on falling sync transition
        logic            clk_norm;   // sample on rising edge, launch on falling
        logic            fs_cons;    // frame sync taken from fs_in
        logic            bclk_cons;  // bit clock taken from bclk_in
        logic [FL_W-1:0] sync_len;   // bit clocks of active sync
        logic [FL_W-1:0] frame_m1;   // bit clocks per frame minus one
    } tcfg_t;

    function automatic logic [FL_W-1:0] step_pos(input logic [FL_W-1:0] cur,
                                                 input logic [FL_W-1:0] last,
                                                 input logic            restart);
        return (restart || cur >= last) ? '0 : cur + 1'b1;
    endfunction

    function automatic logic fs_drive(input logic active, input logic fall);
        return active ^ fall;
    endfunction

endpackage

// File: rtl/pcm_sync_edge.sv
module pcm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pcm_bclk_unit.sv
module pcm_bclk_unit #(
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic consumer,
    input  logic launch_on_fall,
    input  logic bclk_in,
    output logic bclk_o,
    output logic launch_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic bclk_q, rise_q, fall_q;
    logic ext_s, ext_d;
    logic div_wrap;

    pcm_sync_edge #(.STAGES(SYNC_STAGES)) u_bsync (
        .clk (clk),
        .rst (rst),
        .d_i (bclk_in),
        .q_o (ext_s)
    );

    always_ff @(posedge clk) begin
        if (rst) ext_d <= 1'b0;
        else     ext_d <= ext_s;
    end

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign div_wrap = 1'b1;
        end else begin : g_div
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || !en || consumer)          div_q <= '0;
                else if (div_q == DW'(HALF_DIV - 1)) div_q <= '0;
                else                                 div_q <= div_q + 1'b1;
            end
            assign div_wrap = (div_q == DW'(HALF_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            bclk_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else if (consumer) begin
            bclk_q <= 1'b0;
            rise_q <= ext_s & ~ext_d;
            fall_q <= ~ext_s & ext_d;
        end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (div_wrap) begin
                bclk_q <= ~bclk_q;
                rise_q <= ~bclk_q;
                fall_q <= bclk_q;
            end
        end
    end

    assign bclk_o   = bclk_q;
    assign launch_o = launch_on_fall ? fall_q : rise_q;

    assert_one_edge_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise_q, fall_q}));

    assert_rise_level_R3: assert property (@(posedge clk) disable iff (rst)
        (!consumer && rise_q) |-> bclk_q);

    assert_fall_level_R3: assert property (@(posedge clk) disable iff (rst)
        (!consumer && fall_q) |-> !bclk_q);
endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr
    import pcm_tgen_pkg::*;
#(
    parameter int WARM_BITS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            step_raw,
    input  logic [FL_W-1:0] frame_m1,
    input  logic [FL_W-1:0] sync_len,
    input  logic            fs_fall,
    input  logic            fs_cons,
    input  logic            fs_smp,
    output logic            step_o,
    output logic [FL_W-1:0] bit_pos,
    output logic            frame_start,
    output logic            fs_o
);
    localparam int WW = $clog2(WARM_BITS + 1);

    logic [FL_W-1:0] cnt_q, nxt;
    logic [WW-1:0]   warm_q;
    logic            running_q, started_q, fstart_q, fs_prev_q, fs_q;
    logic            resync;

    assign resync = fs_cons & (fs_fall ? (fs_prev_q & ~fs_smp)
                                       : (~fs_prev_q & fs_smp));
    assign nxt    = step_pos(cnt_q, frame_m1, !started_q || resync);
    assign step_o = step_raw & running_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q     <= '0;
            warm_q    <= '0;
            running_q <= 1'b0;
            started_q <= 1'b0;
            fstart_q  <= 1'b0;
            fs_prev_q <= 1'b0;
            fs_q      <= rst ? 1'b0 : fs_fall;
        end else begin
            fstart_q <= 1'b0;
            if (step_raw) begin
                fs_prev_q <= fs_smp;
                if (!running_q) begin
                    warm_q <= warm_q + 1'b1;
                    if (warm_q == WW'(WARM_BITS - 1)) running_q <= 1'b1;
                end else begin
                    cnt_q     <= nxt;
                    fstart_q  <= (nxt == '0);
                    started_q <= 1'b1;
                    fs_q      <= fs_drive(nxt < sync_len, fs_fall);
                end
            end
        end
    end

    assign bit_pos     = cnt_q;
    assign frame_start = fstart_q;
    assign fs_o        = fs_q;

    assert_pos_bound_R1: assert property (@(posedge clk) disable iff (rst)
        step_o |=> (bit_pos <= $past(frame_m1)));

    assert_start_at_zero_R1: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (bit_pos == '0));

    assert_start_single_R1: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    assert_resync_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (step_o && resync) |=> (bit_pos == '0 && frame_start));

    assert_quiet_off_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (bit_pos == '0 && !frame_start));

    assert_warm_gate_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> !step_o);
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_tgen_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int WARM_BITS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tx_on,
    input  logic             rx_on,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             bclk_in,
    input  logic             fs_in,
    output logic             bclk_out,
    output logic             fs_out,
    output logic             bit_step,
    output logic [FL_W-1:0]  bit_pos,
    output logic             frame_start
);
    tcfg_t cfg_q;
    logic  launch, fs_smp, bclk_gen, fs_gen;

    always_ff @(posedge clk) begin
        if (rst)                  cfg_q <= '0;
        else if (!tx_on && !rx_on) cfg_q <= tcfg_t'(cfg_word);
    end

    pcm_bclk_unit #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_bclk (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .consumer       (cfg_q.bclk_cons),
        .launch_on_fall (cfg_q.clk_norm),
        .bclk_in        (bclk_in),
        .bclk_o         (bclk_gen),
        .launch_o       (launch)
    );

    pcm_sync_edge #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk (clk),
        .rst (rst),
        .d_i (fs_in),
        .q_o (fs_smp)
    );

    pcm_frame_ctr #(.WARM_BITS(WARM_BITS)) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .step_raw    (launch),
        .frame_m1    (cfg_q.frame_m1),
        .sync_len    (cfg_q.sync_len),
        .fs_fall     (cfg_q.fs_fall),
        .fs_cons     (cfg_q.fs_cons),
        .fs_smp      (fs_smp),
        .step_o      (bit_step),
        .bit_pos     (bit_pos),
        .frame_start (frame_start),
        .fs_o        (fs_gen)
    );

    assign bclk_out = cfg_q.bclk_cons ? 1'b0 : bclk_gen;
    assign fs_out   = cfg_q.fs_cons   ? 1'b0 : fs_gen;

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_on || rx_on) |=> $stable(cfg_q));

    assert_bclk_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> !bclk_out);
endmodule

// File: tb/sim_pcm_frame_timer.sv
module sim_pcm_frame_timer;
    import pcm_tgen_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;
    localparam int WARM = 4;

    logic clk = 1'b0, rst = 1'b1, en = 1'b0, tx_on = 1'b0, rx_on = 1'b0;
    logic [CFG_W-1:0] cfg_word = '0;
    logic bclk_in = 1'b0, fs_in = 1'b0;
    logic bclk_out, fs_out, bit_step, frame_start;
    logic [FL_W-1:0] bit_pos;

    int tests = 0, fails = 0;
    int m_pos, m_st;
    bit fv [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_frame_timer #(.HALF_DIV(HALF), .WARM_BITS(WARM), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .en(en), .tx_on(tx_on), .rx_on(rx_on),
        .cfg_word(cfg_word), .bclk_in(bclk_in), .fs_in(fs_in),
        .bclk_out(bclk_out), .fs_out(fs_out), .bit_step(bit_step),
        .bit_pos(bit_pos), .frame_start(frame_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [CFG_W-1:0] pack(input bit fall, input bit norm,
        input bit fcons, input bit bcons, input int s, input int l);
        return {fall, norm, fcons, bcons, FL_W'(s), FL_W'(l)};
    endfunction

    // compare outputs on the cycle after a counted step
    task automatic chk_step(input int l, input int s, input bit fall, input bit prov);
        chk(int'(bit_pos) == m_pos, "R1 bit_pos", int'(bit_pos), m_pos);
        chk(frame_start == (m_pos == 0), "R1 frame_start", frame_start, m_pos == 0);
        if (prov) chk(fs_out == ((m_pos < s) ^ fall), "R2 fs_out", fs_out, (m_pos < s) ^ fall);
        else      chk(fs_out == 1'b0, "R6 fs_out held", fs_out, 0);
    endtask

    task automatic run_prov(input int l, input int s, input bit fall, input bit norm,
                            input int nsteps, input bit poke);
        bit prev_b = 0, pend = 0, poked = 0, launch, b;
        int nl = 0, act = 0, since = 0, toggles = 0, guard = 0;
        en = 0; tx_on = 0; rx_on = 0;
        cfg_word = pack(fall, norm, 0, 0, s, l);
        repeat (4) @(negedge clk);
        chk(fs_out == fall, "R8 fs idle level", fs_out, fall);
        m_st = 0; m_pos = 0;
        en = 1;
        while (act < nsteps && guard < 20000) begin
            @(negedge clk);
            guard++; since++;
            if (pend) begin chk_step(l, s, fall, 1); pend = 0; end
            b = bclk_out;
            launch = 0;
            if (b != prev_b) begin
                if (toggles > 0) chk(since == HALF, "R3 half period", since, HALF);
                toggles++; since = 0;
                launch = norm ? (prev_b & ~b) : (~prev_b & b);
            end
            if (launch) begin
                nl++;
                if (nl > WARM) begin
                    chk(bit_step == 1'b1, "R4 step on launch edge", bit_step, 1);
                    act++;
                    m_pos = (!m_st || m_pos >= l) ? 0 : m_pos + 1;
                    m_st = 1; pend = 1;
                end else begin
                    chk(bit_step == 1'b0, "R7 no step in warm-up", bit_step, 0);
                end
            end else if (bit_step) begin
                chk(0, "R4 step off launch edge", 1, 0);
            end
            prev_b = b;
            if (poke && !poked && act == nsteps / 2) begin
                tx_on = 1;
                cfg_word = pack(fall, norm, 0, 0, s, 3);
                poked = 1;
            end
        end
        @(negedge clk);
        if (pend) chk_step(l, s, fall, 1);
        en = 0;
        repeat (3) @(negedge clk);
        chk(bit_pos == '0, "R8 pos idle", int'(bit_pos), 0);
        chk(frame_start == 0 && bit_step == 0, "R8 strobes idle", frame_start | bit_step, 0);
        chk(bclk_out == 0, "R3 bclk idle", bclk_out, 0);
        chk(fs_out == fall, "R8 fs inactive", fs_out, fall);
        tx_on = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_cons(input int l, input int e, input int off, input bit fall,
                            input int nsteps);
        bit pend = 0, det;
        int nl = 0, act = 0, ph = 0, idle = 0, idx;
        en = 0; bclk_in = 0; fs_in = fall;
        cfg_word = pack(fall, 1, 1, 1, 0, l);
        repeat (6) @(negedge clk);
        m_st = 0; m_pos = 0;
        en = 1;
        while (idle < 16) begin
            @(negedge clk);
            if (pend) begin chk_step(l, 0, fall, 0); pend = 0; end
            if (bit_step) begin
                act++;
                idx = WARM + act;
                det = fall ? (fv[idx-1] & ~fv[idx]) : (~fv[idx-1] & fv[idx]);
                m_pos = (!m_st || det || m_pos >= l) ? 0 : m_pos + 1;
                m_st = 1; pend = 1;
                chk(bclk_out == 0, "R5 bclk_out held", bclk_out, 0);
            end
            if (nl < WARM + nsteps) begin
                if (ph == 0) bclk_in = 1;
                if (ph == 4) begin
                    nl++;
                    fv[nl] = ((((nl - 1 + off) % e) < e / 2) ? 1'b1 : 1'b0) ^ fall;
                    bclk_in = 0;
                    fs_in = fv[nl];
                end
                ph = (ph + 1) % 8;
            end else begin
                idle++;
            end
        end
        chk(act == nsteps, "R5 one step per launch edge", act, nsteps);
        en = 0;
        repeat (3) @(negedge clk);
        chk(bit_pos == '0 && fs_out == 0, "R8 consumer idle", int'(bit_pos), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(bclk_out == 0 && fs_out == 0, "R10 reset clk/sync", bclk_out | fs_out, 0);
        chk(bit_pos == '0, "R10 reset pos", int'(bit_pos), 0);
        chk(bit_step == 0 && frame_start == 0, "R10 reset strobes", bit_step | frame_start, 0);
        rst = 0;
        @(negedge clk);
        for (int l = 0; l < 7; l++)
            run_prov(l, (l + 1) / 2, l[0], ~l[1], 3 * (l + 1) + 2, 0);
        run_prov(3, 7, 0, 1, 12, 0);
        run_prov(15, 8, 1, 1, 40, 0);
        run_prov(9, 1, 0, 0, 25, 0);
        run_prov(1023, 512, 0, 1, 1030, 0);
        run_prov(7, 4, 0, 1, 30, 1);  // R9: mid-run word ignored
        run_cons(15, 12, 3, 0, 40);   // R6 rising start
        run_cons(15, 10, 7, 1, 40);   // R6 falling start
        run_cons(5, 12, 0, 0, 30);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule